// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This block sits behind an instruction buffer and examines the two oldest entries, the older one in slot 0 and the younger one in slot 1. Each cycle it decides how many of them leave the buffer: none, one or both. Two instructions leave together only when one goes to the integer pipe and the other goes to the floating-point compute pipe. Those two pipes have different depths, five and seven stages, so each has its own issue enable and its own stall input.

The decision is purely combinational. For each pipe the block reports whether it receives an instruction and which slot that instruction comes from. It also reports a consumed count that the buffer adds to its head pointer. Program order is strict: the younger slot can only leave in the same cycle as the older one. A pair is split when the younger instruction reads a register that the older one writes. Register ids carry a file bit, so integer and FP registers never alias. Writes to the hardwired-zero integer register never create a dependency.

Top module: `dsp_pair_issue`

## Requirements
- R1: A class tag with bit 2 set (codes 4 to 7: FP add, FP subtract, fused multiply-add, format convert) routes to the FP pipe. Codes 0 to 3 route to the integer pipe: ALU, branch, integer load/store and FP load/store. A lone issuable older instruction issues to its own pipe, with count 1 and slot select 0.
- R2: An integer-class and an FP-class pair issues together in either order, with count 2. Each pipe's slot output names its source slot: 0 for the older slot, 1 for the younger slot.
- R3: When both slots hold instructions for the same pipe, only the older one issues and the count is 1.
- R4: The younger slot never issues unless the older slot issues in the same cycle. This holds when the older slot is invalid or blocked.
- R5: An asserted pipe stall blocks every instruction bound for that pipe. A blocked older instruction also holds back the younger one.
- R6: The hazard bit of a slot blocks that slot. A hazard on the younger slot alone leaves the count at 1.
- R7: When the older slot has a valid destination equal to any valid source of the younger slot, only the older slot issues. Register ids are 6 bits: bit 5 set means the FP file, and bits 4:0 give the index.
- R8: No dependency is formed by integer register 0 (id 0x00), by a source whose valid bit is low, or by an older destination whose valid bit is low. FP register 0 (id 0x20) is an ordinary register.
- R9: The count equals the number of pipes issued this cycle. An invalid older slot gives count 0 and all enables low. Each slot select reads 0 when its pipe is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used for checking only |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | 2 | Valid bit per slot, bit 0 = older |
| slot0_cls_i | input | 3 | Class tag of the older slot |
| slot1_cls_i | input | 3 | Class tag of the younger slot |
| hazard_i | input | 2 | Per-slot scoreboard hazard |
| stall_int_i | input | 1 | Integer pipe stall |
| stall_fp_i | input | 1 | FP compute pipe stall |
| slot0_dst_i | input | 6 | Destination register id of the older slot |
| slot0_dst_vld_i | input | 1 | Older slot writes a register |
| slot1_src_i | input | 12 | Two source register ids of the younger slot |
| slot1_src_vld_i | input | 2 | Valid bit per younger source |
| int_issue_o | output | 1 | Integer pipe receives an instruction |
| int_slot_o | output | 1 | Slot feeding the integer pipe |
| fp_issue_o | output | 1 | FP pipe receives an instruction |
| fp_slot_o | output | 1 | Slot feeding the FP pipe |
| count_o | output | 2 | Instructions consumed from the buffer |

## Verification
Class pairing, a pipe stall and a register dependency can all bear on the younger slot in the same cycle. A stall on the older instruction's pipe also cuts off the younger one. The bench provokes these overlaps directly. It stalls the integer pipe under an integer-then-FP pair and under an FP-then-integer pair. It sets a RAW match on an otherwise pairable integer/FP couple. In each case it compares both issue enables, both slot selects and the count against values derived from the requirements.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU  = 3'd0,
    CL_BR   = 3'd1,
    CL_MEM  = 3'd2,
    CL_FMEM = 3'd3,
    CL_FADD = 3'd4,
    CL_FSUB = 3'd5,
    CL_FMA  = 3'd6,
    CL_FCVT = 3'd7
  } cls_e;

  typedef enum logic {
    PIPE_INT = 1'b0,
    PIPE_FP  = 1'b1
  } pipe_e;

  function automatic pipe_e cls_pipe(logic [CLS_W-1:0] c);
    return c[CLS_W-1] ? PIPE_FP : PIPE_INT;
  endfunction
endpackage

// File: rtl/dsp_slot_gate.sv
module dsp_slot_gate
  import dsp_pkg::*;
(
  input  logic             vld_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             hazard_i,
  input  logic             stall_int_i,
  input  logic             stall_fp_i,
  output pipe_e            pipe_o,
  output logic             rdy_o
);
  pipe_e pipe;
  logic  pipe_stall;

  assign pipe       = cls_pipe(cls_i);
  assign pipe_stall = (pipe == PIPE_FP) ? stall_fp_i : stall_int_i;
  assign pipe_o     = pipe;
  assign rdy_o      = vld_i && !hazard_i && !pipe_stall;
endmodule

// File: rtl/dsp_dep_check.sv
module dsp_dep_check #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2,
  localparam int REG_W  = IDX_W + 1
) (
  input  logic [REG_W-1:0]         dst_i,
  input  logic                     dst_vld_i,
  input  logic [NUM_SRC*REG_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]       src_vld_i,
  output logic                     dep_o
);
  logic             dst_live;
  logic [NUM_SRC-1:0] hit;

  // integer register 0 is hardwired and never carries a result
  assign dst_live = dst_vld_i && (dst_i != '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign hit[k] = dst_live && src_vld_i[k] && (src_i[k*REG_W +: REG_W] == dst_i);
  end

  assign dep_o = |hit;
endmodule

// File: rtl/dsp_route.sv
module dsp_route
  import dsp_pkg::*;
(
  input  logic       go0_i,
  input  logic       go1_i,
  input  pipe_e      pipe0_i,
  input  pipe_e      pipe1_i,
  output logic       int_issue_o,
  output logic       int_slot_o,
  output logic       fp_issue_o,
  output logic       fp_slot_o,
  output logic [1:0] count_o
);
  logic int0, int1, fp0, fp1;

  assign int0 = go0_i && (pipe0_i == PIPE_INT);
  assign int1 = go1_i && (pipe1_i == PIPE_INT);
  assign fp0  = go0_i && (pipe0_i == PIPE_FP);
  assign fp1  = go1_i && (pipe1_i == PIPE_FP);

  assign int_issue_o = int0 || int1;
  assign int_slot_o  = int1;
  assign fp_issue_o  = fp0 || fp1;
  assign fp_slot_o   = fp1;
  assign count_o     = {go0_i && go1_i, go0_i ^ go1_i};
endmodule

// File: rtl/dsp_pair_issue.sv
module dsp_pair_issue
  import dsp_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2,
  localparam int REG_W  = IDX_W + 1,
  localparam int NSLOT  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSLOT-1:0]         slot_vld_i,
  input  logic [CLS_W-1:0]         slot0_cls_i,
  input  logic [CLS_W-1:0]         slot1_cls_i,
  input  logic [NSLOT-1:0]         hazard_i,
  input  logic                     stall_int_i,
  input  logic                     stall_fp_i,
  input  logic [REG_W-1:0]         slot0_dst_i,
  input  logic                     slot0_dst_vld_i,
  input  logic [NUM_SRC*REG_W-1:0] slot1_src_i,
  input  logic [NUM_SRC-1:0]       slot1_src_vld_i,
  output logic                     int_issue_o,
  output logic                     int_slot_o,
  output logic                     fp_issue_o,
  output logic                     fp_slot_o,
  output logic [1:0]               count_o
);
  logic [CLS_W-1:0] cls [NSLOT];
  pipe_e            pipe [NSLOT];
  logic             rdy [NSLOT];
  logic             dep, go0, go1;

  assign cls[0] = slot0_cls_i;
  assign cls[1] = slot1_cls_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dsp_slot_gate u_gate (
      .vld_i       (slot_vld_i[s]),
      .cls_i       (cls[s]),
      .hazard_i    (hazard_i[s]),
      .stall_int_i (stall_int_i),
      .stall_fp_i  (stall_fp_i),
      .pipe_o      (pipe[s]),
      .rdy_o       (rdy[s])
    );
  end

  dsp_dep_check #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_dep (
    .dst_i     (slot0_dst_i),
    .dst_vld_i (slot0_dst_vld_i),
    .src_i     (slot1_src_i),
    .src_vld_i (slot1_src_vld_i),
    .dep_o     (dep)
  );

  // younger slot rides only behind an issuing older slot bound for the other pipe
  assign go0 = rdy[0];
  assign go1 = go0 && rdy[1] && (pipe[1] != pipe[0]) && !dep;

  dsp_route u_route (
    .go0_i       (go0),
    .go1_i       (go1),
    .pipe0_i     (pipe[0]),
    .pipe1_i     (pipe[1]),
    .int_issue_o (int_issue_o),
    .int_slot_o  (int_slot_o),
    .fp_issue_o  (fp_issue_o),
    .fp_slot_o   (fp_slot_o),
    .count_o     (count_o)
  );

  AST_PAIR_SPLIT_PIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == 2'd2) |-> (int_issue_o && fp_issue_o && (int_slot_o != fp_slot_o))); // R2
  AST_SAME_PIPE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i == 2'b11 && cls_pipe(slot0_cls_i) == cls_pipe(slot1_cls_i)) |-> (count_o != 2'd2)); // R3
  AST_INT_YOUNG_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_issue_o && int_slot_o) |-> (fp_issue_o && !fp_slot_o)); // R4
  AST_FP_YOUNG_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_issue_o && fp_slot_o) |-> (int_issue_o && !int_slot_o)); // R4
  AST_INT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_int_i |-> !int_issue_o); // R5
  AST_FP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_fp_i |-> !fp_issue_o); // R5
  AST_OLD_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_i[0] |-> (count_o == 2'd0)); // R6
  AST_RAW_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep |-> (count_o != 2'd2)); // R7
  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == ({1'b0, int_issue_o} + {1'b0, fp_issue_o}))); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_vld_i[0] |-> (count_o == 2'd0 && !int_issue_o && !fp_issue_o)); // R9
endmodule

// File: tb/dsp_pair_issue_test.sv
module dsp_pair_issue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  vld;
  logic [2:0]  c0, c1;
  logic [1:0]  hz;
  logic        st_int, st_fp;
  logic [5:0]  dst;
  logic        dst_v;
  logic [11:0] src;
  logic [1:0]  src_v;
  logic        int_iss, int_sl, fp_iss, fp_sl;
  logic [1:0]  cnt;
  int          n_chk = 0;
  int          n_fail = 0;

  localparam logic [2:0] ALU = 3'd0, BR = 3'd1, MEM = 3'd2, FMEM = 3'd3,
                         FADD = 3'd4, FSUB = 3'd5, FMA = 3'd6, FCVT = 3'd7;

  always #10 clk = ~clk;

  dsp_pair_issue uut (
    .clk_i(clk), .rst_ni(rst_n), .slot_vld_i(vld), .slot0_cls_i(c0), .slot1_cls_i(c1),
    .hazard_i(hz), .stall_int_i(st_int), .stall_fp_i(st_fp), .slot0_dst_i(dst),
    .slot0_dst_vld_i(dst_v), .slot1_src_i(src), .slot1_src_vld_i(src_v),
    .int_issue_o(int_iss), .int_slot_o(int_sl), .fp_issue_o(fp_iss), .fp_slot_o(fp_sl),
    .count_o(cnt)
  );

  // expected packed as {int_issue, int_slot, fp_issue, fp_slot, count}
  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    #5;
    got = {int_iss, int_sl, fp_iss, fp_sl, cnt};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    vld = 2'b00; c0 = ALU; c1 = ALU; hz = 2'b00; st_int = 1'b0; st_fp = 1'b0;
    dst = 6'h00; dst_v = 1'b0; src = 12'h000; src_v = 2'b00;
  endtask

  task automatic set_pair(input logic [1:0] v, input logic [2:0] a, input logic [2:0] b);
    clr();
    vld = v; c0 = a; c1 = b;
  endtask

  task automatic t_idle();
    clr();
    check("R9 idle", 6'b00_00_00);
    set_pair(2'b10, ALU, ALU);
    check("R9 younger only", 6'b00_00_00);
  endtask

  task automatic t_single();
    set_pair(2'b01, ALU, ALU);  check("R1 lone alu", 6'b10_00_01);
    set_pair(2'b01, FMEM, ALU); check("R1 fp mem to int", 6'b10_00_01);
    set_pair(2'b01, FCVT, ALU); check("R1 lone convert", 6'b00_10_01);
  endtask

  task automatic t_pair();
    set_pair(2'b11, ALU, FMA);  check("R2 int then fp", 6'b10_11_10);
    set_pair(2'b11, FADD, BR);  check("R2 fp then int", 6'b11_10_10);
    set_pair(2'b11, FMEM, FSUB); check("R2 fp mem with fp sub", 6'b10_11_10);
  endtask

  task automatic t_same();
    set_pair(2'b11, ALU, MEM);   check("R3 two int", 6'b10_00_01);
    set_pair(2'b11, FADD, FSUB); check("R3 two fp", 6'b00_10_01);
    set_pair(2'b11, MEM, FMEM);  check("R3 mem with fp mem", 6'b10_00_01);
  endtask

  task automatic t_order();
    set_pair(2'b11, ALU, FMA);
    hz = 2'b01;
    check("R4 R6 older hazard", 6'b00_00_00);
  endtask

  task automatic t_stall();
    set_pair(2'b11, ALU, FADD); st_fp = 1'b1;
    check("R5 fp stall younger", 6'b10_00_01);
    set_pair(2'b11, ALU, FADD); st_int = 1'b1;
    check("R5 int stall blocks both", 6'b00_00_00);
    set_pair(2'b11, FADD, ALU); st_int = 1'b1;
    check("R5 int stall younger", 6'b00_10_01);
  endtask

  task automatic t_hazard();
    set_pair(2'b11, ALU, FADD); hz = 2'b10;
    check("R6 younger hazard", 6'b10_00_01);
  endtask

  task automatic t_dep();
    set_pair(2'b11, FMEM, FADD); dst = 6'h23; dst_v = 1'b1;
    src = {6'h00, 6'h23}; src_v = 2'b01;
    check("R7 raw src0", 6'b10_00_01);
    src = {6'h23, 6'h05}; src_v = 2'b11;
    check("R7 raw src1", 6'b10_00_01);
    src_v = 2'b01;
    check("R8 src invalid", 6'b10_11_10);
    src = {6'h00, 6'h23}; src_v = 2'b01; dst_v = 1'b0;
    check("R8 dst invalid", 6'b10_11_10);
    set_pair(2'b11, ALU, FCVT); dst = 6'h00; dst_v = 1'b1;
    src = {6'h00, 6'h00}; src_v = 2'b11;
    check("R8 int zero reg", 6'b10_11_10);
    set_pair(2'b11, FMEM, FADD); dst = 6'h20; dst_v = 1'b1;
    src = {6'h00, 6'h20}; src_v = 2'b01;
    check("R8 fp zero reg", 6'b10_00_01);
    set_pair(2'b11, ALU, FADD); dst = 6'h03; dst_v = 1'b1;
    src = {6'h00, 6'h23}; src_v = 2'b01;
    check("R7 file bit differs", 6'b10_11_10);
  endtask

  initial begin
    clr();
    check("R9 reset", 6'b00_00_00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_single();
    t_pair();
    t_same();
    t_order();
    t_stall();
    t_hazard();
    t_dep();
    clr();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule